// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block works out the column address for each beat of a synchronous DRAM burst. A column command (read or write) carries a start column, and a burst length code and an ordering type are sampled with it. Beat 0 is presented in the same clock as the command, so a write can take its first data word in the command cycle. The remaining beats follow on consecutive clocks. Fixed bursts of 2, 4 and 8 keep their beats inside the aligned block of burst-length size. Within that block the order is either sequential with wrap or interleaved, where each beat is the start column XOR the beat index. Full-page bursts step through every column of the row, wrap at the end and keep going until something stops them.

A new column command may arrive at any time, even one clock after the previous one. It cuts the running burst short and starts a fresh one at its own column with its own length and type. A terminate input ends a burst without starting another. The block drives the current column, a beat-valid flag and a burst-done flag that marks the last beat of a fixed-length burst. The data path and row and bank handling sit elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first command, beat_valid and burst_done are low.
- R2: In a cycle with cmd_valid high, beat_valid is high and col_out equals cmd_col (beat 0).
- R3: Length codes on len_code: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, 3'b111 gives full page, and 3'b100 to 3'b110 give 1 beat. Beats come on consecutive clocks with no gap until the burst ends.
- R4: With order_ilv low (sequential) and a fixed length L, beat i is the start column with its low log2(L) bits replaced by (start + i) mod L. The upper bits stay those of the start column.
- R5: With order_ilv high (interleaved) and a fixed length L, beat i is the start column XOR i. Since i < L, only the low log2(L) bits change.
- R6: In full-page mode, beat i is (start + i) mod 2^COL_W whatever the value of order_ilv. The burst has no natural end.
- R7: burst_done is high together with beat_valid on the last beat of a fixed burst, which for length 1 is the command cycle itself. It is never high on a full-page beat after the command cycle.
- R8: A command that arrives during a burst abandons the old burst. Its beat 0 appears in that cycle and later beats follow its own start, length and type.
- R9: term high without cmd_valid ends a running burst, and beat_valid is low from that cycle on. When cmd_valid is high in the same cycle, term has no effect. When no burst is running, term has no effect.
- R10: len_code and order_ilv are sampled only in command cycles. Changing them during a burst does not alter the burst's addresses or length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Column command (read or write) in this cycle |
| cmd_col | input | COL_W | Start column of the command |
| len_code | input | 3 | Burst length code, sampled with the command |
| order_ilv | input | 1 | 1 = interleaved order, 0 = sequential, sampled with the command |
| term | input | 1 | Stop the running burst (ignored alongside a command) |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| burst_done | output | 1 | Current beat is the last of a fixed-length burst |

## Verification
The embedded properties assume that the command inputs are known, non-X levels in every cycle after reset. They also assume that len_code and order_ilv only carry meaning in cycles where cmd_valid is high. Any value may appear on them at other times, and the stimulus deliberately shuffles them every cycle to exercise that. Commands, terminates and codes are drawn at random from a fixed seed, including reserved codes and back-to-back commands. Directed sequences cover the wrap points of sequential and interleaved bursts, full page wrapping past the last column, and terminate coinciding with a command.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // burst length codes as decoded by the sequencer
  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  localparam int unsigned LEN_CODE_W = 3;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [LEN_CODE_W-1:0] code,
  output logic [COL_W-1:0]      len_mask,
  output logic                  full_page,
  output logic                  single
);
  always_comb begin
    len_mask  = '0;
    full_page = 1'b0;
    unique case (len_code_e'(code))
      LEN_2:    len_mask = COL_W'(1);
      LEN_4:    len_mask = COL_W'(3);
      LEN_8:    len_mask = COL_W'(7);
      LEN_PAGE: begin
        len_mask  = '1;
        full_page = 1'b1;
      end
      default:  len_mask = '0;
    endcase
    single = (len_mask == '0);
  end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             term,
  input  logic [COL_W-1:0] dec_mask,
  input  logic             dec_fp,
  input  logic             dec_single,
  input  logic             dec_ilv,
  output logic             act_q,
  output logic [COL_W-1:0] idx_q,
  output logic [COL_W-1:0] start_q,
  output logic [COL_W-1:0] mask_q,
  output logic             fp_q,
  output logic             ilv_q,
  output logic             last_beat
);
  // last beat of a fixed burst: index reached length-1, which equals the mask
  assign last_beat = act_q && !fp_q && (idx_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      idx_q   <= '0;
      start_q <= '0;
      mask_q  <= '0;
      fp_q    <= 1'b0;
      ilv_q   <= 1'b0;
    end else if (cmd_valid) begin
      act_q   <= !dec_single;
      idx_q   <= COL_W'(1);
      start_q <= cmd_col;
      mask_q  <= dec_mask;
      fp_q    <= dec_fp;
      ilv_q   <= dec_ilv && !dec_fp;
    end else if (act_q) begin
      if (term || last_beat) begin
        act_q <= 1'b0;
      end else begin
        idx_q <= idx_q + COL_W'(1);
      end
    end
  end

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(mask_q) && $stable(ilv_q) && $stable(fp_q) && $stable(start_q)));

  // R7
  fp_never_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_q |-> !last_beat);
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  // sequential with wrap inside the aligned block; all-ones mask = full page
  function automatic logic [COL_W-1:0] seq_wrap(
    input logic [COL_W-1:0] s, input logic [COL_W-1:0] i, input logic [COL_W-1:0] m);
    logic [COL_W-1:0] sum;
    sum = s + i;
    return (s & ~m) | (sum & m);
  endfunction

  function automatic logic [COL_W-1:0] ilv_mix(
    input logic [COL_W-1:0] s, input logic [COL_W-1:0] i, input logic [COL_W-1:0] m);
    return s ^ (i & m);
  endfunction

  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] mix_col;

  assign seq_col = seq_wrap(start, idx, mask);
  assign mix_col = ilv_mix(start, idx, mask);
  assign col     = ilv ? mix_col : seq_col;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [COL_W-1:0]      cmd_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  order_ilv,
  input  logic                  term,
  output logic [COL_W-1:0]      col_out,
  output logic                  beat_valid,
  output logic                  burst_done
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_fp;
  logic             dec_single;
  logic             act_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] mask_q;
  logic             fp_q;
  logic             ilv_q;
  logic             last_beat;
  logic [COL_W-1:0] gen_col;

  // named events for the properties
  logic cont_beat;
  logic term_cut;

  bcs_len_decode #(.COL_W(COL_W)) dec_i (
    .code      (len_code),
    .len_mask  (dec_mask),
    .full_page (dec_fp),
    .single    (dec_single)
  );

  bcs_beat_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_col    (cmd_col),
    .term       (term),
    .dec_mask   (dec_mask),
    .dec_fp     (dec_fp),
    .dec_single (dec_single),
    .dec_ilv    (order_ilv),
    .act_q      (act_q),
    .idx_q      (idx_q),
    .start_q    (start_q),
    .mask_q     (mask_q),
    .fp_q       (fp_q),
    .ilv_q      (ilv_q),
    .last_beat  (last_beat)
  );

  bcs_addr_gen #(.COL_W(COL_W)) gen_i (
    .start (start_q),
    .idx   (idx_q),
    .mask  (mask_q),
    .ilv   (ilv_q),
    .col   (gen_col)
  );

  assign cont_beat  = act_q && !term && !cmd_valid;
  assign term_cut   = act_q && term && !cmd_valid;

  assign beat_valid = cmd_valid || cont_beat;
  assign col_out    = cmd_valid ? cmd_col : gen_col;
  assign burst_done = cmd_valid ? dec_single : (cont_beat && last_beat);

  // R2
  cmd_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (beat_valid && col_out == cmd_col));

  // R7
  done_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> beat_valid);

  // R7
  fp_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_beat && fp_q) |-> !burst_done);

  // R3
  beat_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !burst_done) |=> (beat_valid || term));

  // R9
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_cut |=> (!beat_valid || cmd_valid));

  // R4 R5
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_beat && !fp_q) |-> (((col_out ^ $past(col_out)) & ~mask_q) == '0));

  // R6
  fp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_beat && fp_q) |-> (col_out == $past(col_out) + COL_W'(1)));
endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 9;
  localparam int NCOLS      = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [2:0]       len_code = 3'b000;
  logic             order_ilv = 1'b0;
  logic             term = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             beat_valid;
  logic             burst_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model state
  bit    m_act = 0;
  int    m_start = 0;
  int    m_idx = 0;
  int    m_len = 1;   // 0 = full page
  bit    m_ilv = 0;
  string tag_ovr = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
    .len_code(len_code), .order_ilv(order_ilv), .term(term),
    .col_out(col_out), .beat_valid(beat_valid), .burst_done(burst_done)
  );

  function automatic int blen(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int i, input int len, input bit ilv);
    int base;
    if (len == 0) return (s + i) % NCOLS;
    if (ilv) return s ^ i;
    base = s - (s % len);
    return base + ((s % len) + i) % len;
  endfunction

  task automatic chk(input string req, input int actv, input int expv);
    n_chk++;
    if (actv != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actv, expv, $time);
    end
  endtask

  // one clock: drive after negedge, compare, advance model
  task automatic step(input bit c, input int col, input int code, input bit ilv, input bit t);
    bit ev;
    bit ed;
    int ec;
    string cq;
    string vq;
    @(negedge clk);
    cmd_valid = c;
    cmd_col   = COL_W'(col);
    len_code  = 3'(code);
    order_ilv = ilv;
    term      = t;
    #1;
    ev = 0; ed = 0; ec = 0;
    vq = "R3"; cq = "R2";
    if (c) begin
      ev = 1; ec = col; ed = (blen(code) == 1);
      cq = m_act ? "R8" : "R2";
      m_act = (blen(code) != 1); m_start = col; m_idx = 1; m_len = blen(code);
      m_ilv = ilv && (blen(code) != 0);
    end else if (m_act && t) begin
      vq = "R9";
      m_act = 0;
    end else if (m_act) begin
      ev = 1;
      ec = exp_col(m_start, m_idx, m_len, m_ilv);
      ed = (m_len != 0) && (m_idx == m_len - 1);
      cq = (m_len == 0) ? "R6" : (m_ilv ? "R5" : "R4");
      if (ed) m_act = 0;
      m_idx = (m_len == 0) ? (m_idx + 1) % NCOLS : m_idx + 1;
    end else if (t) begin
      vq = "R9";
    end
    if (tag_ovr != "") begin
      cq = tag_ovr; vq = tag_ovr;
    end
    chk(vq, int'(beat_valid), int'(ev));
    chk("R7", int'(burst_done), int'(ed));
    if (ev && beat_valid) chk(cq, int'(col_out), ec);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1 reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R1", int'(beat_valid), 0);
      chk("R1", int'(burst_done), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R4 sequential BL8 from 13: 13,14,15,8,9,10,11,12
    step(1, 13, 3, 0, 0); idle(8);
    // R5 interleaved BL8 from 13: 13,12,15,14,9,8,11,10
    step(1, 13, 3, 1, 0); idle(8);
    // R5 interleaved BL4 from 6
    step(1, 6, 2, 1, 0); idle(4);
    // R7 single beat and reserved code
    step(1, 300, 0, 0, 0); idle(1);
    step(1, 301, 5, 1, 0); idle(1);
    // R6 full page wrapping past the last column, interleave ignored, then term
    step(1, 509, 7, 1, 0); idle(6); step(0, 0, 0, 0, 1); idle(2);
    // R8 interrupt BL8 after two beats, new BL2 interleaved
    step(1, 40, 3, 0, 0); idle(1); step(1, 101, 1, 1, 0); idle(3);
    // R9 term with a command is ignored; term while idle does nothing
    step(1, 200, 2, 0, 0); step(1, 77, 2, 0, 1); idle(4);
    step(0, 0, 0, 0, 1); idle(1);
    // R10 mode pins change mid-burst
    step(1, 250, 3, 0, 0);
    tag_ovr = "R10";
    for (int k = 0; k < 7; k++) step(0, k * 31, k % 8, k % 2, 0);
    tag_ovr = "";
    idle(2);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit c;
      bit t;
      int code;
      int pick;
      c = ($urandom_range(0, 5) == 0);
      t = ($urandom_range(0, 19) == 0);
      pick = $urandom_range(0, 11);
      code = (pick < 10) ? ((pick < 2) ? 7 : pick % 4) : $urandom_range(4, 6);
      step(c, $urandom_range(0, NCOLS - 1), code, 1'($urandom_range(0, 1)), t);
    end
    idle(2);
    finish_run();
  end
endmodule